// File: doc/BRIEF.md
# Master Clock Period Monitor

This block watches an audio master clock and reports when that clock has slowed down or stopped. The clock under watch arrives asynchronously. It is brought into a fast reference clock domain, and its rising edges are detected there. Between each pair of detected rising edges, a counter running on the reference clock measures the gap. At every rising edge after the first, the measured gap is compared with a programmable limit. A gap strictly longer than the limit raises a sticky interrupt and freezes the counter, so that the offending measurement can still be read.

Software sets the limit from the reference frequency and the expected master clock frequency. Software then enables the block. When the interrupt fires, software reads the frozen count and pulses the clear input to rearm the block. Dropping the enable also rearms it. After rearming, the first rising edge only starts a new measurement and is never judged.

Top module: `mclk_period_monitor`

## Requirements
- R1: After reset, `irq`, `measuring` and `count_val` are all zero.
- R2: Each detected rising edge of `mclk_in` restarts the count from zero. The count then grows by one per reference cycle, so the value held at the next rising edge is the edge spacing in reference cycles minus one.
- R3: At each rising edge seen while measuring, a held count strictly greater than `limit_val` sets `irq`. A count equal to or below `limit_val` leaves `irq` low, and measurement goes on.
- R4: Once set, `irq` stays high while `enable` is high and no `irq_clr` pulse arrives, whatever `mclk_in` does.
- R5: While `irq` is high, `count_val` is frozen at the count that caused the trip.
- R6: The count saturates at its all-ones value and never wraps. A saturated count compared against an all-ones limit does not trip.
- R7: An `irq_clr` pulse while tripped lowers `irq` and `measuring` on the next cycle and zeroes the count. The first rising edge after that starts measuring (`measuring` = 1) without any comparison.
- R8: With `enable` low, the block sits idle, with `irq`, `measuring` and `count_val` all zero. Raising `enable` again behaves like a rearm: the first edge is not compared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_in | input | 1 | Master clock under watch, asynchronous |
| limit_val | input | CNT_W | Largest accepted count between rising edges |
| enable | input | 1 | Monitor enable; low holds the block idle |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| irq | output | 1 | Sticky out-of-range interrupt |
| measuring | output | 1 | High while a period is being timed |
| count_val | output | CNT_W | Current count, or the frozen count after a trip |

## Verification
The bench builds the block with `CNT_W` = 8 and the default two-stage synchronizer. The narrow counter lets a stopped master clock drive the count to saturation within a few hundred reference cycles. That makes the no-wrap rule reachable, along with the all-ones limit corner. With limit 20, periods of 21 and 22 reference cycles probe exactly the two sides of the strict greater-than test.

// File: rtl/mcpm_pkg.sv
package mcpm_pkg;
   typedef enum logic [1:0] {
      MS_IDLE = 2'd0,
      MS_ARM  = 2'd1,
      MS_RUN  = 2'd2,
      MS_TRIP = 2'd3
   } mon_state_e;
endpackage

// File: rtl/mcpm_edge_sync.sv
module mcpm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;
   logic          prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mcpm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= async_in;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[LAST];
   end

   assign rise_pulse = chain[LAST] & ~prev_q;
endmodule

// File: rtl/mcpm_period_counter.sv
module mcpm_period_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         zero,
   input  logic         advance,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (zero)                       cnt <= '0;
      else if (advance && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mcpm_ctrl.sv
module mcpm_ctrl
   import mcpm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic irq_clr,
   input  logic rise,
   input  logic over_limit,
   output logic cnt_zero,
   output logic cnt_advance,
   output logic irq,
   output logic measuring
);
   mon_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!enable) begin
         state_d = MS_IDLE;
      end else begin
         case (state_q)
            MS_IDLE: state_d = MS_ARM;
            MS_ARM:  if (rise) state_d = MS_RUN;
            MS_RUN:  if (rise && over_limit) state_d = MS_TRIP;
            MS_TRIP: if (irq_clr) state_d = MS_ARM;
            default: state_d = MS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= MS_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      cnt_zero    = 1'b0;
      cnt_advance = 1'b0;
      case (state_q)
         MS_IDLE: cnt_zero = 1'b1;
         MS_ARM:  cnt_zero = 1'b1;
         MS_RUN: begin
            cnt_zero    = rise && !over_limit;
            cnt_advance = !rise;
         end
         MS_TRIP: cnt_zero = irq_clr;
         default: cnt_zero = 1'b1;
      endcase
      if (!enable) cnt_zero = 1'b1;
   end

   assign irq       = (state_q == MS_TRIP);
   assign measuring = (state_q == MS_RUN);
endmodule

// File: rtl/mclk_period_monitor.sv
module mclk_period_monitor #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             mclk_in,
   input  logic [CNT_W-1:0] limit_val,
   input  logic             enable,
   input  logic             irq_clr,
   output logic             irq,
   output logic             measuring,
   output logic [CNT_W-1:0] count_val
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("mclk_period_monitor: CNT_W must lie in 2..32");
      end
   endgenerate

   logic rise;
   logic over_limit;
   logic cnt_zero;
   logic cnt_advance;

   mcpm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .async_in   (mclk_in),
      .rise_pulse (rise)
   );

   mcpm_period_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .zero    (cnt_zero),
      .advance (cnt_advance),
      .cnt     (count_val)
   );

   assign over_limit = (count_val > limit_val);

   mcpm_ctrl u_ctrl (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .enable      (enable),
      .irq_clr     (irq_clr),
      .rise        (rise),
      .over_limit  (over_limit),
      .cnt_zero    (cnt_zero),
      .cnt_advance (cnt_advance),
      .irq         (irq),
      .measuring   (measuring)
   );
endmodule

// File: rtl/mcpm_checker.sv
module mcpm_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk_ref,
   input logic             rst_n,
   input logic             enable,
   input logic             irq_clr,
   input logic             irq,
   input logic             measuring,
   input logic [CNT_W-1:0] count_val
);
   localparam logic [CNT_W-1:0] SAT = '1;

   AST_IRQ_HOLDS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (irq && enable && !irq_clr) |=> irq); // R4

   AST_COUNT_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (irq && enable && !irq_clr) |=> $stable(count_val)); // R5

   AST_NO_WRAP: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (count_val == SAT) |=> (count_val == SAT || count_val == '0)); // R6

   AST_CLEAR_REARMS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (irq && irq_clr && enable) |=> (!irq && !measuring && count_val == '0)); // R7

   AST_TRIP_FROM_RUN: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(irq) |-> $past(measuring)); // R3

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !enable |=> (!irq && !measuring && count_val == '0)); // R8

   AST_EXCLUSIVE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !(irq && measuring)); // R3
endmodule

bind mclk_period_monitor mcpm_checker #(.CNT_W(CNT_W)) u_chk (
   .clk_ref   (clk_ref),
   .rst_n     (rst_n),
   .enable    (enable),
   .irq_clr   (irq_clr),
   .irq       (irq),
   .measuring (measuring),
   .count_val (count_val)
);

// File: tb/tb_mclk_period_monitor.sv
module tb_mclk_period_monitor;
   localparam int W = 8;

   logic         clk_ref = 1'b0;
   logic         rst_n = 1'b0;
   logic         mclk_in = 1'b0;
   logic [W-1:0] limit_val = '0;
   logic         enable = 1'b0;
   logic         irq_clr = 1'b0;
   logic         irq;
   logic         measuring;
   logic [W-1:0] count_val;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   always #4 clk_ref = ~clk_ref;

   mclk_period_monitor #(.CNT_W(W), .SYNC_STAGES(2)) dut (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .mclk_in   (mclk_in),
      .limit_val (limit_val),
      .enable    (enable),
      .irq_clr   (irq_clr),
      .irq       (irq),
      .measuring (measuring),
      .count_val (count_val)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_ref);
   endtask

   task automatic periods(input int p, input int n);
      for (int k = 0; k < n; k++) begin
         mclk_in = 1'b1;
         idle(p / 2);
         mclk_in = 1'b0;
         idle(p - p / 2);
      end
   endtask

   task automatic t_reset();
      idle(3);
      chk("R1", "irq", irq, 0);
      chk("R1", "measuring", measuring, 0);
      chk("R1", "count_val", count_val, 0);
   endtask

   task automatic t_first_edge();
      limit_val = 8'd20;
      enable = 1'b1;
      idle(100);
      chk("R8", "count held at zero before first edge", count_val, 0);
      chk("R8", "measuring before first edge", measuring, 0);
      periods(20, 1);
      chk("R8", "first edge after enable not compared", irq, 0);
      chk("R8", "measuring after first edge", measuring, 1);
      periods(20, 4);
      chk("R3", "period 20 under limit 20", irq, 0);
   endtask

   task automatic t_boundary();
      periods(21, 4);
      chk("R3", "count equal to limit does not trip", irq, 0);
      periods(22, 2);
      chk("R3", "count above limit trips", irq, 1);
      chk("R2", "held count is spacing minus one", count_val, 21);
      periods(10, 5);
      chk("R4", "irq sticky under further edges", irq, 1);
      chk("R5", "count frozen after trip", count_val, 21);
      chk("R5", "measuring low while tripped", measuring, 0);
   endtask

   task automatic t_clear();
      irq_clr = 1'b1;
      @(negedge clk_ref);
      irq_clr = 1'b0;
      chk("R7", "irq after clear", irq, 0);
      chk("R7", "measuring after clear", measuring, 0);
      chk("R7", "count after clear", count_val, 0);
      idle(100);
      periods(10, 1);
      chk("R7", "first edge after clear not compared", irq, 0);
      chk("R7", "measuring after first edge", measuring, 1);
      periods(10, 3);
      chk("R7", "short periods after clear", irq, 0);
   endtask

   task automatic t_saturate();
      limit_val = 8'd255;
      idle(400);
      chk("R6", "count saturates", count_val, 255);
      chk("R6", "no trip while saturating", irq, 0);
      periods(10, 1);
      chk("R6", "saturated count vs all-ones limit", irq, 0);
      chk("R6", "still measuring", measuring, 1);
      periods(10, 2);
      limit_val = 8'd254;
      idle(400);
      chk("R6", "count saturated again", count_val, 255);
      periods(10, 1);
      chk("R6", "saturated count above 254 trips", irq, 1);
      chk("R6", "frozen at saturated value", count_val, 255);
   endtask

   task automatic t_disable();
      enable = 1'b0;
      idle(2);
      chk("R8", "irq when disabled", irq, 0);
      chk("R8", "measuring when disabled", measuring, 0);
      chk("R8", "count when disabled", count_val, 0);
      periods(50, 2);
      chk("R8", "edges ignored while disabled", measuring, 0);
      chk("R8", "irq stays low while disabled", irq, 0);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      t_reset();
      t_first_edge();
      t_boundary();
      t_clear();
      t_saturate();
      t_disable();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 50000; i++) @(posedge clk_ref);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule